// File: doc/BRIEF.md
# Repeating Port-to-Memory Byte Input Engine

This engine performs the repeating "input from port, store at pointer" loop of an 8-bit processor as a standalone hardware sequence. A start strobe loads the 16-bit port-address pair (a count byte in the high half, a port-select byte in the low half) and a 16-bit memory pointer. On each pass it reads one byte from the I/O port addressed by the whole pair and stores it at the pointer. It then advances the pointer, counts the high byte down and recomputes the complete flag byte, including the bits processors set in ways that are not officially specified. The loop runs until the count byte reaches zero.

Both the port read and the memory write are valid/ready channels. The engine raises `valid` with a stable address (and write data) and holds them until the peer raises `ready`. A transfer happens on every rising edge where both are high, so the peer may apply back-pressure for any number of cycles. For the read channel, the read data is taken in the same cycle as the handshake. The engine also keeps an instruction-accurate T-state total for the whole run. That total is independent of how many clock cycles back-pressure costs. A one-cycle `done` pulse presents the final register pair, pointer, flags and T-state total.

Top module: `io_block_in_engine`

## Requirements
- R1: After reset, `busy`, `done`, `io_rd_valid` and `mem_wr_valid` are 0 and `tstates` is 0.
- R2: Each port read presents `io_rd_addr` = {count byte, port byte}, using the count value before that pass's decrement. `io_rd_valid` and the address hold steady until `io_rd_ready` is seen high at a rising edge, and `io_rd_data` is taken at that edge.
- R3: Each byte read is written with `mem_wr_data` equal to that byte at `mem_wr_addr` equal to the current pointer. The write is held until `mem_wr_ready`, and the pointer then increases by one, wrapping from 0xFFFF to 0x0000.
- R4: The count byte decreases by one per pass and the run ends after the pass that makes it zero. A count of 0 at start gives 256 passes, and the final pair always has a zero high byte.
- R5: Flag byte layout is bit 7 S, bit 6 Z, bit 5 Y, bit 4 H, bit 3 X, bit 2 P/V, bit 1 N, bit 0 C. S, Z, Y and X come from the decremented count: S is its bit 7, Z is set when it is zero, Y is its bit 5 and X is its bit 3.
- R6: N equals bit 7 of the byte transferred in that pass.
- R7: H and C both equal the carry out of the 9-bit sum of the transferred byte and ((port byte + 1) mod 256).
- R8: P/V is set when ((low 8 bits of that sum) AND 7) XOR decremented count has an even number of ones.
- R9: Each pass costs 13 T-states (5 + 3 + 4 + 1), plus 5 more when the decremented count is nonzero. `tstates` restarts at 0 on an accepted start, so a run of n passes reports 18n - 5.
- R10: `done` is high for exactly one cycle after the last write completes, with `out_bc`, `out_hl`, `out_flags` and `tstates` holding the final values. `busy` is high from the cycle after an accepted start until the cycle after `done`.
- R11: A `start` while `busy` is high is ignored, and the running transfer finishes with its original values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| start_bc | input | 16 | Initial count byte (high) and port byte (low) |
| start_hl | input | 16 | Initial memory pointer |
| busy | output | 1 | Run in progress |
| io_rd_valid | output | 1 | Port read request valid |
| io_rd_addr | output | 16 | Port read address |
| io_rd_ready | input | 1 | Port read accepted, data present |
| io_rd_data | input | 8 | Byte read from the port |
| mem_wr_valid | output | 1 | Memory write valid |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| mem_wr_ready | input | 1 | Memory write accepted |
| tstates | output | 16 | T-state total of the current or last run |
| done | output | 1 | One-cycle completion pulse |
| out_bc | output | 16 | Final count/port pair |
| out_hl | output | 16 | Final memory pointer |
| out_flags | output | 8 | Final flag byte |

## Verification
Random port bytes, port selects and counts under random back-pressure on both channels exercise the flag derivation across many carry and parity combinations. They also show that stalls never change the T-state total. A single pass (count 1) separates the last-pass cost from the repeat cost. A start count of 0 distinguishes the 256-pass wrap from an immediate exit. A pointer of 0xFFFF exposes a missing 16-bit wrap. A port byte of 0xFF (increment wraps to 0, no carry) and transferred byte 0xFF with port byte 0 (carry out) separate the two halves of the carry rule. A start pulsed mid-run shows whether a busy engine wrongly reloads.

// File: rtl/io_in_pkg.sv
package io_in_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_UPD,
    ST_DONE
  } eng_state_t;

  localparam int unsigned FLAG_S  = 7;
  localparam int unsigned FLAG_Z  = 6;
  localparam int unsigned FLAG_Y  = 5;
  localparam int unsigned FLAG_H  = 4;
  localparam int unsigned FLAG_X  = 3;
  localparam int unsigned FLAG_PV = 2;
  localparam int unsigned FLAG_N  = 1;
  localparam int unsigned FLAG_C  = 0;

  localparam int unsigned COST_FETCH  = 5;
  localparam int unsigned COST_IORD   = 3;
  localparam int unsigned COST_MEMWR  = 4;
  localparam int unsigned COST_EXTRA  = 1;
  localparam int unsigned COST_REPEAT = 5;
endpackage

// File: rtl/io_in_flags.sv
module io_in_flags
  import io_in_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] xfer_byte,
  input  logic [DW-1:0] port_byte,
  input  logic [DW-1:0] cnt_next,
  output logic [7:0]    flags
);
  logic [DW-1:0] port_inc;
  logic [DW:0]   sum_w;
  logic [DW-1:0] par_vec;

  always_comb begin
    port_inc = port_byte + 1'b1;
    sum_w    = {1'b0, xfer_byte} + {1'b0, port_inc};
    par_vec  = (sum_w[DW-1:0] & DW'(7)) ^ cnt_next;
    flags            = '0;
    flags[FLAG_S]    = cnt_next[DW-1];
    flags[FLAG_Z]    = (cnt_next == '0);
    flags[FLAG_Y]    = cnt_next[5];
    flags[FLAG_X]    = cnt_next[3];
    flags[FLAG_H]    = sum_w[DW];
    flags[FLAG_C]    = sum_w[DW];
    flags[FLAG_N]    = xfer_byte[DW-1];
    flags[FLAG_PV]   = ~(^par_vec);
  end
endmodule

// File: rtl/io_in_tstates.sv
module io_in_tstates
  import io_in_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          rpt,
  output logic [TW-1:0] count
);
  localparam logic [TW-1:0] PASS_COST =
    TW'(COST_FETCH + COST_IORD + COST_MEMWR + COST_EXTRA);
  localparam logic [TW-1:0] RPT_COST = TW'(COST_REPEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clr)    count <= '0;
    else if (step)   count <= count + PASS_COST + (rpt ? RPT_COST : '0);
  end

  // R9
  tstate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (count - $past(count)) == (($past(rpt)) ? PASS_COST + RPT_COST : PASS_COST));

  // R9
  tstate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(count));
endmodule

// File: rtl/io_block_in_engine.sv
module io_block_in_engine
  import io_in_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned TW = 16,
  localparam int unsigned PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] start_bc,
  input  logic [PW-1:0] start_hl,
  output logic          busy,
  output logic          io_rd_valid,
  output logic [PW-1:0] io_rd_addr,
  input  logic          io_rd_ready,
  input  logic [DW-1:0] io_rd_data,
  output logic          mem_wr_valid,
  output logic [PW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ready,
  output logic [TW-1:0] tstates,
  output logic          done,
  output logic [PW-1:0] out_bc,
  output logic [PW-1:0] out_hl,
  output logic [7:0]    out_flags
);
  eng_state_t    state_q;
  logic [DW-1:0] cnt_q, port_q, data_q, cnt_next;
  logic [PW-1:0] ptr_q;
  logic [7:0]    flags_q, flags_new;
  logic          accept_start, upd;

  assign accept_start = start && (state_q == ST_IDLE);
  assign upd          = (state_q == ST_UPD);
  assign cnt_next     = cnt_q - 1'b1;

  io_in_flags #(.DW(DW)) flags_i (
    .xfer_byte (data_q),
    .port_byte (port_q),
    .cnt_next  (cnt_next),
    .flags     (flags_new)
  );

  io_in_tstates #(.TW(TW)) tcnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_start),
    .step  (upd),
    .rpt   (cnt_next != '0),
    .count (tstates)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      port_q  <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      flags_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          cnt_q   <= start_bc[PW-1:DW];
          port_q  <= start_bc[DW-1:0];
          ptr_q   <= start_hl;
          state_q <= ST_READ;
        end
        ST_READ: if (io_rd_ready) begin
          data_q  <= io_rd_data;
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (mem_wr_ready) state_q <= ST_UPD;
        ST_UPD: begin
          cnt_q   <= cnt_next;
          ptr_q   <= ptr_q + 1'b1;
          flags_q <= flags_new;
          state_q <= (cnt_next == '0) ? ST_DONE : ST_READ;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign io_rd_valid  = (state_q == ST_READ);
  assign io_rd_addr   = {cnt_q, port_q};
  assign mem_wr_valid = (state_q == ST_WRITE);
  assign mem_wr_addr  = ptr_q;
  assign mem_wr_data  = data_q;
  assign out_bc       = {cnt_q, port_q};
  assign out_hl       = ptr_q;
  assign out_flags    = flags_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_valid && !io_rd_ready) |=> (io_rd_valid && $stable(io_rd_addr)));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_valid && io_rd_ready) |=> (mem_wr_valid && mem_wr_data == $past(io_rd_data)));

  // R4
  final_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_bc[PW-1:DW] == '0));

  // R10
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_rd_valid, mem_wr_valid, done}));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && io_rd_valid && !io_rd_ready) |=> $stable(out_bc) && $stable(out_hl));
endmodule

// File: tb/io_block_in_engine_tb_top.sv
`timescale 1ns/1ps
module io_block_in_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_bc = '0, start_hl = '0;
  logic        busy, io_rd_valid, mem_wr_valid, done;
  logic [15:0] io_rd_addr, mem_wr_addr, tstates, out_bc, out_hl;
  logic        io_rd_ready = 1'b0, mem_wr_ready = 1'b0;
  logic [7:0]  io_rd_data = '0, mem_wr_data, out_flags;

  int checks = 0;
  int fails  = 0;
  int total_cycles = 0;

  always #2 clk = ~clk;

  io_block_in_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bc(start_bc), .start_hl(start_hl),
    .busy(busy), .io_rd_valid(io_rd_valid), .io_rd_addr(io_rd_addr),
    .io_rd_ready(io_rd_ready), .io_rd_data(io_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready), .tstates(tstates), .done(done),
    .out_bc(out_bc), .out_hl(out_hl), .out_flags(out_flags)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_flags(input logic [7:0] d, input logic [7:0] c,
                                             input logic [7:0] bn);
    int s, ones;
    logic [7:0] f, v;
    s = int'(d) + ((int'(c) + 1) % 256);
    v = 8'((s % 256) % 8) ^ bn;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    f = '0;
    f[7] = bn[7];
    f[6] = (bn == 8'd0);
    f[5] = bn[5];
    f[3] = bn[3];
    f[4] = (s > 255);
    f[0] = (s > 255);
    f[2] = (ones % 2 == 0);
    f[1] = d[7];
    return f;
  endfunction

  task automatic run_xfer(input logic [15:0] bc, input logic [15:0] hl,
                          input int stall_pct, input bit poke, input int force_data);
    logic [7:0] b, c, cur, bn, ef;
    logic [15:0] h;
    int n, passes, cyc;
    bit poked, finished;
    b = bc[15:8]; c = bc[7:0]; h = hl; ef = '0; cur = '0;
    n = (b == 0) ? 256 : int'(b);
    passes = 0; cyc = 0; poked = 0; finished = 0;
    @(negedge clk);
    start = 1'b1; start_bc = bc; start_hl = hl;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
    while (!finished) begin
      if (start) start = 1'b0;
      io_rd_ready = 1'b0; mem_wr_ready = 1'b0;
      if (io_rd_valid) begin
        chk(io_rd_addr == {b, c}, "R2", "io_rd_addr", int'(io_rd_addr), int'({b, c}));
        if (poke && !poked) begin
          start = 1'b1; start_bc = 16'h0707; start_hl = 16'h4321; poked = 1;
        end else if (($urandom % 100) >= stall_pct) begin
          io_rd_ready = 1'b1;
          cur = (force_data >= 0) ? 8'(force_data) : 8'($urandom);
          io_rd_data = cur;
        end
      end
      if (mem_wr_valid) begin
        chk(mem_wr_addr == h, "R3", "mem_wr_addr", int'(mem_wr_addr), int'(h));
        chk(mem_wr_data == cur, "R3", "mem_wr_data", int'(mem_wr_data), int'(cur));
        if (($urandom % 100) >= stall_pct) begin
          mem_wr_ready = 1'b1;
          bn = b - 8'd1;
          ef = model_flags(cur, c, bn);
          b = bn; h = h + 16'd1; passes++;
        end
      end
      if (done) begin
        chk(passes == n, "R4", "pass count", passes, n);
        chk(out_bc == {8'd0, c}, "R4", "out_bc", int'(out_bc), int'({8'd0, c}));
        chk(out_hl == h, "R3", "out_hl", int'(out_hl), int'(h));
        chk(out_flags[7] == ef[7] && out_flags[6] == ef[6] && out_flags[5] == ef[5]
            && out_flags[3] == ef[3], "R5", "S/Z/Y/X", int'(out_flags), int'(ef));
        chk(out_flags[1] == ef[1], "R6", "N", int'(out_flags), int'(ef));
        chk(out_flags[4] == ef[4] && out_flags[0] == ef[0], "R7", "H/C",
            int'(out_flags), int'(ef));
        chk(out_flags[2] == ef[2], "R8", "P/V", int'(out_flags), int'(ef));
        chk(int'(tstates) == 18 * n - 5, "R9", "tstates", int'(tstates), 18 * n - 5);
        finished = 1;
      end
      @(negedge clk);
      cyc++; total_cycles++;
      if (cyc > 20000) begin
        chk(1'b0, "R10", "watchdog run timeout", cyc, 0);
        finished = 1;
      end
    end
    io_rd_ready = 1'b0; mem_wr_ready = 1'b0;
    chk(done == 1'b0 && busy == 1'b0, "R10", "done single pulse / idle",
        int'({done, busy}), 0);
    if (poke) chk(poked, "R11", "mid-run start issued", int'(poked), 1);
  endtask

  initial begin
    void'($urandom(32'h1B0C_0093));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", int'({busy, done}), 0);
    chk(io_rd_valid == 0 && mem_wr_valid == 0, "R1", "valids in reset",
        int'({io_rd_valid, mem_wr_valid}), 0);
    chk(tstates == 16'd0, "R1", "tstates in reset", int'(tstates), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1", "idle after reset", int'(busy), 0);
    // R9 single pass: no repeat cost
    run_xfer(16'h0140, 16'h2000, 0, 0, -1);
    // R3 pointer wrap
    run_xfer(16'h0312, 16'hFFFF, 30, 0, -1);
    // R7 port byte 0xFF: increment wraps, no carry
    run_xfer(16'h02FF, 16'h1000, 0, 0, 8'hFF);
    // R7 byte 0xFF with port byte 0: carry
    run_xfer(16'h0200, 16'h1100, 0, 0, 8'hFF);
    // R11 start while busy ignored
    run_xfer(16'h0433, 16'h3000, 20, 1, -1);
    // R4 start count zero means 256 passes
    run_xfer(16'h00A5, 16'h8000, 10, 0, -1);
    for (int t = 0; t < 12; t++) begin
      logic [15:0] rbc;
      rbc = {8'(($urandom % 24) + 1), 8'($urandom)};
      run_xfer(rbc, 16'($urandom), int'($urandom % 60), 0, -1);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 global watchdog actual=0x%0h expected=0x0", total_cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule